// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a two-channel UART register file. A host reaches the registers over a four-wire SPI link: chip select (active low), a serial clock that idles low, a data line into the slave and a data line out of it. The slave turns each transaction into register strobes that the register file consumes. The register contents, the FIFOs and the UART engines sit outside this block.

Every transaction opens with a command byte that carries three fields: a direction flag, a register index and a channel number. One or more data bytes follow while chip select stays low. Every data byte in the burst re-targets the same register and channel, so a host can fill a transmit FIFO or drain a receive FIFO through one register index. The serial clock, chip select and input data are oversampled by the system clock through synchronizer stages. The block therefore runs entirely in the system clock domain, and the serial clock has to stay well below the system clock rate.

The register file presents the byte at the head of the selected register on `regRData` at all times. A read strobe from this block pops that byte. The strobe is issued only when the host actually clocks the first bit of a data byte.

Top module: `spi_reg_slave`

## Requirements
- R1: Command byte bits, in transmit order, are: direction (1 = read, 0 = write), register index bit 3 down to bit 0, channel bit 1, channel bit 0, and a final bit that is ignored. After the command, `regAddr` and `regChan` hold the decoded index and channel.
- R2: In a write, each data byte is taken most significant bit first. It produces exactly one single-cycle `regWr` pulse with the byte on `regWData`.
- R3: Every further data byte of a burst produces a new strobe with the same `regAddr` and `regChan` as the first.
- R4: In a read, `miso` shows bit 7 of `regRData` after the serial clock falls at the end of the command. It then shows bits 6 down to 0 on the following falling edges, each valid for sampling on the next rising edge.
- R5: In a read, each data byte produces exactly one single-cycle `regRd` pulse, issued when the host clocks the byte's first bit. A later byte in the burst carries the updated `regRData`.
- R6: Channel values 2 and 3 are reserved. Such a write produces no strobe. Such a read produces no strobe, returns all-zero bytes on `miso`, and leaves the register file head unconsumed.
- R7: Chip select going high at any bit aborts the transaction. A partial byte produces no strobe, and the next transaction is decoded from its own first bit.
- R8: Out of reset, `regWr`, `regRd` and `miso` are low.
- R9: `miso` is low while chip select is high, throughout the command byte, and throughout write data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from host, sampled on rising serial clock |
| miso | output | 1 | Serial data to host, changes after falling serial clock |
| regRd | output | 1 | One-cycle read strobe; pops the head of the addressed register |
| regWr | output | 1 | One-cycle write strobe |
| regAddr | output | 4 | Register index from the command byte |
| regChan | output | 2 | Channel number from the command byte |
| regWData | output | 8 | Write data, valid with `regWr` |
| regRData | input | 8 | Head byte of the addressed register, presented continuously |

## Verification
The bench streams multi-byte write and read bursts and checks that every byte yields exactly one strobe at the right index and channel. A design that issued read strobes one byte ahead would drain a FIFO entry the host never clocked, and that shows up as an unexpected strobe or a skipped head value. Reserved-channel transfers are followed by a normal read to prove that nothing was popped. Transactions are cut short both inside a data byte and inside the command byte. A bit counter that survives chip select would then misparse the next command, and a design that flushed partial bytes would emit a stray write. The ignored trailing command bit is set in one case, so a decoder shifted by one position would report the wrong channel.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Strobes from the sequencing control to the datapath, all single-cycle.
  typedef struct packed {
    logic csIdle;     // chip select (synchronized) is high
    logic sampleBit;  // qualified rising serial clock edge
    logic cmdDone;    // last bit of the command byte sampled
    logic byteStart;  // first bit of a data byte sampled
    logic byteDone;   // last bit of a data byte sampled
    logic peekHead;   // falling edge before a data byte: present MSB
    logic shiftOut;   // falling edge inside a data byte: next bit
  } ctlStrobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output logic       mosiS,
  output ctlStrobe_t strb
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, mosiPipe;
  logic csS, sclkS, sclkPrev;
  logic riseEdge, fallEdge;
  logic [CNT_W-1:0] bitCnt;
  phase_t phase;

  // Equal-depth synchronizers keep data aligned with the clock edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  assign riseEdge = !csS && sclkS && !sclkPrev;
  assign fallEdge = !csS && !sclkS && sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
    end else if (csS) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
    end else if (riseEdge) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt <= '0;
        phase  <= PH_DATA;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.csIdle    = csS;
    strb.sampleBit = riseEdge;
    strb.cmdDone   = riseEdge && (phase == PH_CMD)  && (bitCnt == LAST_BIT);
    strb.byteStart = riseEdge && (phase == PH_DATA) && (bitCnt == '0);
    strb.byteDone  = riseEdge && (phase == PH_DATA) && (bitCnt == LAST_BIT);
    strb.peekHead  = fallEdge && (phase == PH_DATA) && (bitCnt == '0);
    strb.shiftOut  = fallEdge && (phase == PH_DATA) && (bitCnt != '0);
  end

  // R7: a high chip select leaves the sequencer at the start of a command.
  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0 && phase == PH_CMD));

  // R1: the command byte ends after exactly one full byte of rising edges.
  assert_enter_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    (riseEdge && phase == PH_CMD && bitCnt == LAST_BIT) |=> (phase == PH_DATA && bitCnt == '0));

  // R4: a falling edge never both presents a head bit and shifts.
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.peekHead, strb.shiftOut, strb.sampleBit}) <= 1);

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_W   = 2,
  parameter int DATA_W   = 8,
  parameter int NUM_CHAN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] regRData,
  output logic              miso,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [CHAN_W-1:0] regChan,
  output logic [DATA_W-1:0] regWData
);

  // Command layout: [DATA_W-1] direction, then index, then channel, then spare.
  localparam int ADDR_HI = DATA_W - 2;
  localparam int CHAN_HI = ADDR_HI - ADDR_W;

  logic [DATA_W-2:0] inShift;
  logic [DATA_W-1:0] fullByte;
  logic [DATA_W-1:0] outShift;
  logic              cmdRw;
  logic [ADDR_W-1:0] cmdAddr;
  logic [CHAN_W-1:0] cmdChan;
  logic              chanOk;
  logic              rdActive;
  logic              misoQ;
  logic              regWrQ;
  logic [DATA_W-1:0] regWDataQ;

  assign fullByte = {inShift, mosiS};
  assign chanOk   = cmdChan < CHAN_W'(NUM_CHAN);
  assign rdActive = cmdRw && chanOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
    end else if (strb.sampleBit) begin
      inShift <= fullByte[DATA_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRw   <= 1'b0;
      cmdAddr <= '0;
      cmdChan <= '0;
    end else if (strb.cmdDone) begin
      cmdRw   <= fullByte[DATA_W-1];
      cmdAddr <= fullByte[ADDR_HI -: ADDR_W];
      cmdChan <= fullByte[CHAN_HI -: CHAN_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrQ    <= 1'b0;
      regWDataQ <= '0;
    end else begin
      regWrQ <= strb.byteDone && !cmdRw && chanOk;
      if (strb.byteDone) regWDataQ <= fullByte;
    end
  end

  // Read pop happens when the host clocks the byte's first bit.
  assign regRd = strb.byteStart && rdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      misoQ    <= 1'b0;
    end else if (strb.csIdle) begin
      outShift <= '0;
      misoQ    <= 1'b0;
    end else begin
      if (regRd) begin
        outShift <= {regRData[DATA_W-2:0], 1'b0};
      end else if (strb.shiftOut) begin
        outShift <= {outShift[DATA_W-2:0], 1'b0};
      end
      if (strb.peekHead) begin
        misoQ <= rdActive ? regRData[DATA_W-1] : 1'b0;
      end else if (strb.shiftOut) begin
        misoQ <= outShift[DATA_W-1];
      end
    end
  end

  assign miso     = misoQ;
  assign regWr    = regWrQ;
  assign regWData = regWDataQ;
  assign regAddr  = cmdAddr;
  assign regChan  = cmdChan;

  assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr);

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd);

  assert_target_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmdDone |=> ($stable(regAddr) && $stable(regChan)));

  assert_wr_reserved_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (regChan < CHAN_W'(NUM_CHAN)));

  assert_rd_reserved_R6: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (regChan < CHAN_W'(NUM_CHAN)));

  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.csIdle |=> !miso);

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W      = 4,
  parameter int CHAN_W      = 2,
  parameter int DATA_W      = 8,
  parameter int NUM_CHAN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [CHAN_W-1:0] regChan,
  output logic [DATA_W-1:0] regWData,
  input  logic [DATA_W-1:0] regRData
);

  spi_reg_pkg::ctlStrobe_t strb;
  logic mosiS;

  spi_reg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_BITS  (DATA_W)
  ) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .mosi (mosi),
    .mosiS(mosiS),
    .strb (strb)
  );

  spi_reg_dp #(
    .ADDR_W  (ADDR_W),
    .CHAN_W  (CHAN_W),
    .DATA_W  (DATA_W),
    .NUM_CHAN(NUM_CHAN)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .mosiS   (mosiS),
    .regRData(regRData),
    .miso    (miso),
    .regRd   (regRd),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regChan (regChan),
    .regWData(regWData)
  );

endmodule

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;

  localparam int HALF = 8;  // system clocks per serial half period

  typedef struct {
    logic       isWr;
    logic [3:0] addr;
    logic [1:0] chan;
    logic [7:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, regRd, regWr;
  logic [3:0] regAddr;
  logic [1:0] regChan;
  logic [7:0] regWData, regRData, headByte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regChan(regChan),
    .regWData(regWData), .regRData(regRData)
  );

  // Register file model: a head byte that advances on every pop.
  always @(posedge clk) begin
    if (!rstN) headByte <= 8'hA0;
    else if (regRd) headByte <= headByte + 8'd1;
  end
  assign regRData = headByte;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic isWr, input logic [3:0] a,
                         input logic [1:0] c, input logic [7:0] d);
    item_t it;
    it.isWr = isWr; it.addr = a; it.chan = c; it.data = d;
    expQ.push_back(it);
  endtask

  // Scoreboard monitor: each strobe pops one expected item.
  always @(negedge clk) begin
    if (rstN && (regWr || regRd)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R7", "unexpected strobe wr/rd", {regWr, regRd}, 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(regWr == e.isWr && regRd == !e.isWr, e.isWr ? "R2" : "R5",
              "strobe kind", regWr, e.isWr);
        check(regAddr == e.addr && regChan == e.chan, "R3", "target addr/chan",
              {regAddr, regChan}, {e.addr, e.chan});
        if (e.isWr)
          check(regWData == e.data, "R2", "write data", regWData, e.data);
      end
    end
  end

  task automatic spiBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nBits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic csBegin();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csFinish();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(!regWr && !regRd && !miso, "R8", "outputs after reset",
          {regWr, regRd, miso}, 0);

    // R2/R9: single write, index 5 channel 1
    pushExp(1'b1, 4'h5, 2'd1, 8'h3C);
    csBegin();
    spiBits(8'h2A, 8, rx);
    check(rx == 8'h00, "R9", "miso during command", rx, 0);
    spiBits(8'h3C, 8, rx);
    check(rx == 8'h00, "R9", "miso during write data", rx, 0);
    csFinish();

    // R3: burst write, index A channel 0
    pushExp(1'b1, 4'hA, 2'd0, 8'h81);
    pushExp(1'b1, 4'hA, 2'd0, 8'h7E);
    pushExp(1'b1, 4'hA, 2'd0, 8'h55);
    csBegin();
    spiBits(8'h50, 8, rx);
    spiBits(8'h81, 8, rx);
    spiBits(8'h7E, 8, rx);
    spiBits(8'h55, 8, rx);
    csFinish();

    // R4/R5: burst read, index 0 channel 0, head values A0..A2
    pushExp(1'b0, 4'h0, 2'd0, 8'h00);
    pushExp(1'b0, 4'h0, 2'd0, 8'h00);
    pushExp(1'b0, 4'h0, 2'd0, 8'h00);
    csBegin();
    spiBits(8'h80, 8, rx);
    spiBits(8'h00, 8, rx);
    check(rx == 8'hA0, "R4", "read byte 0", rx, 8'hA0);
    spiBits(8'h00, 8, rx);
    check(rx == 8'hA1, "R5", "read byte 1", rx, 8'hA1);
    spiBits(8'h00, 8, rx);
    check(rx == 8'hA2, "R5", "read byte 2", rx, 8'hA2);
    csFinish();

    // R1: read index F channel 1
    pushExp(1'b0, 4'hF, 2'd1, 8'h00);
    csBegin();
    spiBits(8'hFA, 8, rx);
    spiBits(8'h00, 8, rx);
    check(rx == 8'hA3, "R4", "read channel 1", rx, 8'hA3);
    csFinish();
    check(regAddr == 4'hF && regChan == 2'd1, "R1", "decoded index/channel",
          {regAddr, regChan}, {4'hF, 2'd1});

    // R6: reserved channel 2 write and channel 3 read
    csBegin();
    spiBits(8'h1C, 8, rx);
    spiBits(8'h99, 8, rx);
    csFinish();
    csBegin();
    spiBits(8'h9E, 8, rx);
    spiBits(8'h00, 8, rx);
    check(rx == 8'h00, "R6", "reserved read data", rx, 0);
    spiBits(8'h00, 8, rx);
    check(rx == 8'h00, "R6", "reserved read data burst", rx, 0);
    csFinish();
    // R6: head not consumed, next read returns A4
    pushExp(1'b0, 4'h0, 2'd0, 8'h00);
    csBegin();
    spiBits(8'h80, 8, rx);
    spiBits(8'h00, 8, rx);
    check(rx == 8'hA4, "R6", "head after reserved read", rx, 8'hA4);
    csFinish();

    // R7: abort inside a data byte, then inside a command byte
    csBegin();
    spiBits(8'h2A, 8, rx);
    spiBits(8'hFF, 4, rx);
    csFinish();
    csBegin();
    spiBits(8'h80, 3, rx);
    csFinish();
    pushExp(1'b1, 4'h2, 2'd0, 8'h5A);
    csBegin();
    spiBits(8'h10, 8, rx);
    spiBits(8'h5A, 8, rx);
    csFinish();

    // R1: trailing command bit set is ignored
    pushExp(1'b1, 4'h5, 2'd1, 8'hC3);
    csBegin();
    spiBits(8'h2B, 8, rx);
    spiBits(8'hC3, 8, rx);
    csFinish();

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3", "all expected strobes seen", expQ.size(), 0);
    check(!miso, "R9", "miso idle at end", miso, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule